// File: doc/BRIEF.md
# Sequential Burst Memory-Cycle Generator

This block sits between a processor's multi-word load/store logic and the data memory port. A command gives a start address, a word count, a direction and a protection tag. From that single command the block issues one word access per unstalled cycle. It drives the word address, an active-low request strobe, a flag that marks sequential accesses, and a lookahead flag. The lookahead flag announces one cycle early that the next access will be sequential, so address decode outside the block gets a full extra cycle to prepare.

The memory port is pipelined. Each access has an address phase, and its data phase follows in the next cycle. For a store burst, the words are taken in order from a write queue and shown on the write-data bus during each data phase. For a load burst, the read bus is sampled at the end of each data phase and pushed into a read queue, which the user then drains. A stall input from memory freezes the whole pipeline. A command is admitted only when the queue for its direction can serve the whole burst, so a burst never has to pause for data.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset and whenever no access is in its address phase, `mem_req_n` is 1 and both `mem_seq` and `mem_more` are 0. After reset `cmd_ready` is 1 and `rq_empty` is 1.
- R2: The first access of a burst starts in the cycle after the command is taken. Its address is `cmd_addr` with bits [1:0] cleared, and `mem_seq` is 0. Every issued address has bits [1:0] equal to 0.
- R3: A burst of N words issues exactly N accesses, one per cycle in which `mem_stall` is 0. Each access after the first has `mem_seq` = 1 and an address 4 higher than the previous access, modulo 2^ADDR_W.
- R4: `mem_more` is 1 in a cycle exactly when the next access is a sequential access of the same burst. It is 0 for a single-word burst and on the final access of any burst, and it is never 1 while `mem_req_n` is 1.
- R5: `mem_write` (1 = store, 0 = load) and `mem_prot` keep the values captured at command time for every access of the burst.
- R6: While `mem_stall` is 1 at a clock edge, `mem_addr`, `mem_req_n`, `mem_seq` and `mem_more` keep their values through that edge, and no access or data phase advances.
- R7: In a store burst, the k-th word pushed into the write queue appears on `mem_wdata` throughout the data phase of access k, which is the cycle after its address phase, extended by stalls. Outside store data phases `mem_wdata` is 0. `wq_full` is 1 when the write queue holds WQ_DEPTH words.
- R8: In a load burst, `mem_rdata` is captured at the clock edge that ends the data phase of access k (where `mem_stall` is 0) and queued in order. `rq_data` shows the oldest queued word, `rq_pop` removes it, and `rq_empty` is 1 when the queue is empty. Values on `mem_rdata` at other edges are not captured.
- R9: `cmd_ready` is 1 only when no access is in its address or data phase. A command is taken when `cmd_valid`, `cmd_ready` and a length in range are present, `mem_stall` is 0, and one more condition holds: for a store, the write queue holds at least `cmd_len` words; for a load, the read queue has at least `cmd_len` free entries. Any other command is ignored.
- R10: `cmd_len` must be between 1 and MAX_LEN (16 by default). A length of 0 or above MAX_LEN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Burst command present |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_len | input | LEN_W | Word count, 1 to MAX_LEN |
| cmd_write | input | 1 | 1 = store burst, 0 = load burst |
| cmd_prot | input | PROT_W | Protection tag for the whole burst |
| cmd_ready | output | 1 | Block idle, able to take a command |
| wq_push | input | 1 | Push a store word into the write queue |
| wq_data | input | DATA_W | Store word to push |
| wq_full | output | 1 | Write queue full |
| rq_pop | input | 1 | Remove the oldest loaded word |
| rq_data | output | DATA_W | Oldest loaded word |
| rq_empty | output | 1 | Read queue empty |
| mem_addr | output | ADDR_W | Word address of the access in its address phase |
| mem_req_n | output | 1 | Active-low memory request |
| mem_seq | output | 1 | Current access is sequential |
| mem_more | output | 1 | Next access will be sequential (one-cycle lookahead) |
| mem_write | output | 1 | Direction of the burst |
| mem_prot | output | PROT_W | Protection tag of the burst |
| mem_wdata | output | DATA_W | Store data for the access in its data phase |
| mem_rdata | input | DATA_W | Load data from memory |
| mem_stall | input | 1 | Memory not ready; hold the pipeline |

## Verification
The assertions check several rules on every cycle. They check that the lookahead flag only rises under an active request, that an unstalled lookahead is followed by a sequential access at the address four higher, and that an unstalled access without lookahead is followed by a non-sequential cycle. They also check that a stall freezes the address-phase outputs, that direction and protection hold across sequential accesses, and that issued addresses stay word aligned. Other properties depend on the whole burst, and only the bench scenarios can show them. These are the exact access count, the pairing of queued store words with their data phases, the order of captured load words, and which commands are refused for length, queue room or stall. The bench also covers address wrap-around.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;
endpackage

// File: rtl/burst_fifo.sv
module burst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             do_push, do_pop;

  // Push is dropped when full, pop is dropped when empty.
  assign do_push = push && (count_q != CNT_W'(DEPTH));
  assign do_pop  = pop  && (count_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (do_push) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (do_pop)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage carries no reset; only the pointers define validity.
  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_ptr_q] <= push_data;
  end

  assign head  = store_q[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 32,
  parameter int PROT_W = 2,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  burst_pkg::dir_e   ld_dir,
  input  logic [PROT_W-1:0] ld_prot,
  output logic              ap_valid,
  output logic [ADDR_W-1:0] ap_addr,
  output logic              ap_seq,
  output logic              ap_more,
  output burst_pkg::dir_e   ap_dir,
  output logic [PROT_W-1:0] ap_prot
);
  import burst_pkg::*;

  logic              vld_q,   vld_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [LEN_W-1:0]  left_q,  left_d;
  logic              first_q, first_d;
  dir_e              dir_q,   dir_d;
  logic [PROT_W-1:0] prot_q,  prot_d;
  logic              has_next;

  assign has_next = left_q > LEN_W'(1);

  always_comb begin
    vld_d   = vld_q;
    addr_d  = addr_q;
    left_d  = left_q;
    first_d = first_q;
    dir_d   = dir_q;
    prot_d  = prot_q;
    if (load) begin
      vld_d   = 1'b1;
      addr_d  = {ld_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      left_d  = ld_len;
      first_d = 1'b1;
      dir_d   = ld_dir;
      prot_d  = ld_prot;
    end else if (vld_q) begin
      first_d = 1'b0;
      if (has_next) begin
        addr_d = addr_q + ADDR_W'(WORD_BYTES);
        left_d = left_q - LEN_W'(1);
      end else begin
        vld_d  = 1'b0;
        left_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      dir_q   <= DIR_LOAD;
      prot_q  <= '0;
    end else if (step_en) begin
      vld_q   <= vld_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      first_q <= first_d;
      dir_q   <= dir_d;
      prot_q  <= prot_d;
    end
  end

  assign ap_valid = vld_q;
  assign ap_addr  = addr_q;
  assign ap_seq   = vld_q && !first_q;
  assign ap_more  = vld_q && has_next;
  assign ap_dir   = dir_q;
  assign ap_prot  = prot_q;
endmodule

// File: rtl/burst_data_phase.sv
module burst_data_phase (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            ap_valid,
  input  burst_pkg::dir_e ap_dir,
  output logic            dp_valid,
  output logic            dp_store,
  output logic            wq_take,
  output logic            rq_capture
);
  import burst_pkg::*;

  logic vld_q, vld_d;
  logic st_q,  st_d;

  always_comb begin
    vld_d = ap_valid;
    st_d  = ap_valid && (ap_dir == DIR_STORE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      st_q  <= 1'b0;
    end else if (step_en) begin
      vld_q <= vld_d;
      st_q  <= st_d;
    end
  end

  assign dp_valid   = vld_q;
  assign dp_store   = vld_q && st_q;
  assign wq_take    = vld_q && st_q && step_en;
  assign rq_capture = vld_q && !st_q && step_en;
endmodule

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PROT_W   = 2,
  parameter int MAX_LEN  = 16,
  parameter int WQ_DEPTH = 16,
  parameter int RQ_DEPTH = 16,
  parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_write,
  input  logic [PROT_W-1:0] cmd_prot,
  output logic              cmd_ready,
  input  logic              wq_push,
  input  logic [DATA_W-1:0] wq_data,
  output logic              wq_full,
  input  logic              rq_pop,
  output logic [DATA_W-1:0] rq_data,
  output logic              rq_empty,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_req_n,
  output logic              mem_seq,
  output logic              mem_more,
  output logic              mem_write,
  output logic [PROT_W-1:0] mem_prot,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_stall
);
  import burst_pkg::*;

  localparam int WQ_CNT_W = $clog2(WQ_DEPTH + 1);
  localparam int RQ_CNT_W = $clog2(RQ_DEPTH + 1);

  logic                rst_n_core;
  logic                step_en;
  logic                idle;
  logic                len_ok, room_ok, accept;
  dir_e                cmd_dir;
  logic                ap_valid, ap_seq, ap_more;
  logic [ADDR_W-1:0]   ap_addr;
  dir_e                ap_dir;
  logic [PROT_W-1:0]   ap_prot;
  logic                dp_valid, dp_store, wq_take, rq_capture;
  logic [DATA_W-1:0]   wq_head;
  logic [WQ_CNT_W-1:0] wq_count;
  logic [RQ_CNT_W-1:0] rq_count;

  burst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  // Admission: idle, length in range, no stall, queue can serve the burst.
  assign step_en = !mem_stall;
  assign idle    = !ap_valid && !dp_valid;
  assign cmd_dir = cmd_write ? DIR_STORE : DIR_LOAD;
  assign len_ok  = (cmd_len != '0) && (int'(cmd_len) <= MAX_LEN);

  always_comb begin
    if (cmd_dir == DIR_STORE) room_ok = int'(wq_count) >= int'(cmd_len);
    else                      room_ok = (RQ_DEPTH - int'(rq_count)) >= int'(cmd_len);
  end

  assign accept = cmd_valid && idle && step_en && len_ok && room_ok;

  burst_addr_seq #(
    .ADDR_W (ADDR_W),
    .PROT_W (PROT_W),
    .LEN_W  (LEN_W)
  ) u_addr_seq (
    .clk      (clk),
    .rst_n    (rst_n_core),
    .step_en  (step_en),
    .load     (accept),
    .ld_addr  (cmd_addr),
    .ld_len   (cmd_len),
    .ld_dir   (cmd_dir),
    .ld_prot  (cmd_prot),
    .ap_valid (ap_valid),
    .ap_addr  (ap_addr),
    .ap_seq   (ap_seq),
    .ap_more  (ap_more),
    .ap_dir   (ap_dir),
    .ap_prot  (ap_prot)
  );

  burst_data_phase u_data_phase (
    .clk        (clk),
    .rst_n      (rst_n_core),
    .step_en    (step_en),
    .ap_valid   (ap_valid),
    .ap_dir     (ap_dir),
    .dp_valid   (dp_valid),
    .dp_store   (dp_store),
    .wq_take    (wq_take),
    .rq_capture (rq_capture)
  );

  burst_fifo #(
    .WIDTH (DATA_W),
    .DEPTH (WQ_DEPTH),
    .CNT_W (WQ_CNT_W)
  ) u_wq (
    .clk       (clk),
    .rst_n     (rst_n_core),
    .push      (wq_push),
    .push_data (wq_data),
    .pop       (wq_take),
    .head      (wq_head),
    .count     (wq_count)
  );

  burst_fifo #(
    .WIDTH (DATA_W),
    .DEPTH (RQ_DEPTH),
    .CNT_W (RQ_CNT_W)
  ) u_rq (
    .clk       (clk),
    .rst_n     (rst_n_core),
    .push      (rq_capture),
    .push_data (mem_rdata),
    .pop       (rq_pop),
    .head      (rq_data),
    .count     (rq_count)
  );

  assign cmd_ready = idle;
  assign wq_full   = wq_count == WQ_CNT_W'(WQ_DEPTH);
  assign rq_empty  = rq_count == '0;
  assign mem_addr  = ap_addr;
  assign mem_req_n = !ap_valid;
  assign mem_seq   = ap_seq;
  assign mem_more  = ap_more;
  assign mem_write = ap_dir == DIR_STORE;
  assign mem_prot  = ap_prot;
  assign mem_wdata = dp_store ? wq_head : '0;
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int PROT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_req_n,
  input logic              mem_seq,
  input logic              mem_more,
  input logic              mem_write,
  input logic [PROT_W-1:0] mem_prot,
  input logic              mem_stall,
  input logic              cmd_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_n |-> (!mem_seq && !mem_more)); // R1

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_n |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_SEQ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_more && !mem_stall) |=> (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R3

  AST_MORE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_more |-> !mem_req_n); // R4

  AST_MORE_PREDICTS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_more && !mem_stall) |=> (!mem_req_n && mem_seq)); // R4

  AST_NO_MORE_NO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && !mem_more && !mem_stall) |=> !mem_seq); // R4

  AST_ATTR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_seq |-> ($stable(mem_write) && $stable(mem_prot))); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> ($stable(mem_addr) && $stable(mem_req_n) && $stable(mem_seq) && $stable(mem_more))); // R6

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> mem_req_n); // R9
endmodule

bind burst_seq_gen burst_seq_gen_chk #(
  .ADDR_W (ADDR_W),
  .PROT_W (PROT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_req_n (mem_req_n),
  .mem_seq   (mem_seq),
  .mem_more  (mem_more),
  .mem_write (mem_write),
  .mem_prot  (mem_prot),
  .mem_stall (mem_stall),
  .cmd_ready (cmd_ready)
);

// File: tb/burst_seq_gen_tb.sv
module burst_seq_gen_tb;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int PROT_W = 2;
  localparam int LEN_W  = 5;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              cmd_write;
  logic [PROT_W-1:0] cmd_prot;
  logic              cmd_ready;
  logic              wq_push;
  logic [DATA_W-1:0] wq_data;
  logic              wq_full;
  logic              rq_pop;
  logic [DATA_W-1:0] rq_data;
  logic              rq_empty;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_req_n;
  logic              mem_seq;
  logic              mem_more;
  logic              mem_write;
  logic [PROT_W-1:0] mem_prot;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_stall;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] wq_m [$];
  logic [DATA_W-1:0] rexp [16];

  burst_seq_gen u_dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_addr (cmd_addr), .cmd_len (cmd_len),
    .cmd_write (cmd_write), .cmd_prot (cmd_prot), .cmd_ready (cmd_ready),
    .wq_push (wq_push), .wq_data (wq_data), .wq_full (wq_full),
    .rq_pop (rq_pop), .rq_data (rq_data), .rq_empty (rq_empty),
    .mem_addr (mem_addr), .mem_req_n (mem_req_n), .mem_seq (mem_seq),
    .mem_more (mem_more), .mem_write (mem_write), .mem_prot (mem_prot),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_stall (mem_stall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base, input int k);
    return {base[ADDR_W-1:2], 2'b00} + ADDR_W'(4 * k);
  endfunction

  function automatic logic exp_more(input int k, input int len);
    return (k + 1) < len;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wq_push = 1'b1;
      wq_data = $urandom;
      wq_m.push_back(wq_data);
      @(posedge clk);
    end
    @(negedge clk);
    wq_push = 1'b0;
  endtask

  task automatic drain_reads(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(rq_empty == 1'b0, "R8 rq_empty during drain", 64'(rq_empty), 64'd0);
      chk(rq_data == rexp[k], "R8 load word order", 64'(rq_data), 64'(rexp[k]));
      rq_pop = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    rq_pop = 1'b0;
    chk(rq_empty == 1'b1, "R8 rq_empty after drain", 64'(rq_empty), 64'd1);
  endtask

  task automatic run_burst(input logic [ADDR_W-1:0] addr, input int len, input logic wr,
                           input logic [PROT_W-1:0] prot, input int stall_pct, input logic do_drain);
    int ap;
    int dp;
    logic stalled;
    string tag;
    if (wr && wq_m.size() < len) push_words(len - wq_m.size());
    if (!wr) for (int k = 0; k < len; k++) rexp[k] = $urandom;
    @(negedge clk);
    mem_stall = 1'b0;
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = LEN_W'(len);
    cmd_write = wr;   cmd_prot = prot;
    @(posedge clk);
    ap = 0; dp = -1; stalled = 1'b0;
    while (ap >= 0 || dp >= 0) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      tag = stalled ? "R6" : "R3";
      if (ap >= 0) begin
        chk(mem_req_n == 1'b0, {tag, " request active"}, 64'(mem_req_n), 64'd0);
        chk(mem_addr == exp_addr(addr, ap), ap == 0 ? "R2 first address" : {tag, " address"},
            64'(mem_addr), 64'(exp_addr(addr, ap)));
        chk(mem_seq == (ap != 0), ap == 0 ? "R2 first non-seq" : {tag, " seq flag"},
            64'(mem_seq), 64'(ap != 0));
        chk(mem_more == exp_more(ap, len), "R4 lookahead", 64'(mem_more), 64'(exp_more(ap, len)));
        chk(mem_write == wr && mem_prot == prot, "R5 attributes", {mem_write, mem_prot}, {wr, prot});
        if (ap == 0) chk(cmd_ready == 1'b0, "R9 busy not ready", 64'(cmd_ready), 64'd0);
      end else begin
        chk(mem_req_n == 1'b1 && mem_more == 1'b0, "R3 no extra access",
            {mem_req_n, mem_more}, {1'b1, 1'b0});
      end
      if (dp >= 0 && wr)
        chk(mem_wdata == wq_m[dp], "R7 store data", 64'(mem_wdata), 64'(wq_m[dp]));
      else
        chk(mem_wdata == '0, "R7 idle wdata", 64'(mem_wdata), 64'd0);
      mem_rdata = (dp >= 0 && !wr) ? rexp[dp] : $urandom;
      stalled   = (($urandom % 100) < 32'(stall_pct));
      mem_stall = stalled;
      @(posedge clk);
      if (!stalled) begin
        dp = ap;
        if (ap >= 0) ap = (ap + 1 < len) ? ap + 1 : -1;
      end
    end
    @(negedge clk);
    mem_stall = 1'b0;
    chk(cmd_ready == 1'b1 && mem_req_n == 1'b1, "R9 ready after burst",
        {cmd_ready, mem_req_n}, {1'b1, 1'b1});
    if (wr) for (int k = 0; k < len; k++) void'(wq_m.pop_front());
    if (!wr && do_drain) drain_reads(len);
  endtask

  task automatic try_reject(input int len, input logic wr, input logic stall_v, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 32'h0000_1000; cmd_len = LEN_W'(len);
    cmd_write = wr;   cmd_prot = 2'b01; mem_stall = stall_v;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; mem_stall = 1'b0;
    chk(mem_req_n == 1'b1, tag, 64'(mem_req_n), 64'd1);
    chk(cmd_ready == 1'b1, tag, 64'(cmd_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_A7C3));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_write = 1'b0;
    cmd_prot = '0; wq_push = 1'b0; wq_data = '0; rq_pop = 1'b0; mem_rdata = '0; mem_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(mem_req_n == 1'b1 && mem_seq == 1'b0 && mem_more == 1'b0, "R1 reset strobes",
        {mem_req_n, mem_seq, mem_more}, {1'b1, 1'b0, 1'b0});
    chk(cmd_ready == 1'b1 && rq_empty == 1'b1 && wq_full == 1'b0, "R1 reset ready/queues",
        {cmd_ready, rq_empty, wq_full}, {1'b1, 1'b1, 1'b0});

    // Single-word bursts: non-sequential, lookahead low (R4)
    run_burst(32'h0000_0104, 1, 1'b1, 2'b10, 0, 1'b1);
    run_burst(32'h0000_0207, 1, 1'b0, 2'b01, 0, 1'b1);

    // Unaligned start is truncated to a word (R2)
    run_burst(32'h0000_3003, 5, 1'b0, 2'b11, 0, 1'b1);

    // Full write queue and a maximum-length store (R7)
    push_words(16);
    chk(wq_full == 1'b1, "R7 wq_full at depth", 64'(wq_full), 64'd1);
    run_burst(32'h0001_0000, 16, 1'b1, 2'b00, 0, 1'b1);

    // Long load with heavy stalls (R6, R8)
    run_burst(32'h0002_0040, 16, 1'b0, 2'b01, 40, 1'b1);
    run_burst(32'h0002_8000, 9, 1'b1, 2'b10, 40, 1'b1);

    // Address wrap-around (R3)
    run_burst(32'hFFFF_FFF8, 4, 1'b0, 2'b00, 10, 1'b1);

    // Length out of range ignored (R10)
    try_reject(0, 1'b0, 1'b0, "R10 zero length ignored");
    try_reject(17, 1'b0, 1'b0, "R10 over-length ignored");

    // Command under stall ignored (R9)
    try_reject(2, 1'b0, 1'b1, "R9 command during stall ignored");

    // Store without enough queued words ignored, queued words intact (R9)
    push_words(2);
    try_reject(3, 1'b1, 1'b0, "R9 store short of data ignored");
    run_burst(32'h0000_5000, 2, 1'b1, 2'b11, 0, 1'b1);

    // Load without read-queue room ignored (R9)
    run_burst(32'h0000_6000, 16, 1'b0, 2'b10, 0, 1'b0);
    try_reject(1, 1'b0, 1'b0, "R9 load without room ignored");
    drain_reads(16);

    // Constrained random bursts
    for (int i = 0; i < 40; i++) begin
      run_burst($urandom, 1 + int'($urandom % 16), 1'($urandom), 2'($urandom), 25, 1'b1);
    end

    @(negedge clk);
    chk(mem_req_n == 1'b1 && mem_more == 1'b0 && mem_seq == 1'b0, "R1 idle at end",
        {mem_req_n, mem_more, mem_seq}, {1'b1, 1'b0, 1'b0});
    summary();
    $finish;
  end
endmodule